// File: doc/BRIEF.md
# Pulse-Swallow Modulus Control Counters

This block sits between a dual-modulus prescaler (divide by 128 or 129) and the phase detector of a frequency synthesizer. It is clocked by the prescaler output, so one clock period is one prescaler cycle. Two down-counters run side by side. The swallow counter starts from the programmed A value. The main counter runs through N count periods per output cycle. While the swallow counter is non-zero, the modulus output asks the prescaler for divide-by-129. Once the swallow counter reaches zero it stays there and the modulus output drops to divide-by-128. When the main counter reaches zero, the block emits one output pulse and both counters reload. The oscillator-to-pulse ratio is therefore 128*N + A.

New A and N values arrive on parallel ports with a load strobe. They are written into shadow registers and reach the counters only at a reload, so a cycle already in progress always finishes with the values it started with. A pair that breaks the rule A < N is refused: the shadow registers keep their previous contents and an error flag is raised.

Top module: `swallow_ctr`

## Requirements
- R1: Out of reset, the counters hold the parameter defaults (A=5, N=20), `cfg_err_o` is 0, `pulse_o` is 0 and `mod_hi_o` is 1.
- R2: Within a cycle the swallow counter stops at zero and stays there until the main counter reloads, so every divide-by-129 period comes before every divide-by-128 period.
- R3: When the main counter reaches zero, both counters reload from the shadow registers, so each output cycle lasts exactly N count-clock periods.
- R4: `mod_hi_o` = 1 selects divide-by-129 and `mod_hi_o` = 0 selects divide-by-128. `mod_hi_o` is 1 for exactly the first A periods of each cycle and is 0 during the period in which the pulse is issued.
- R5: With a prescaler that divides by 129 when `mod_hi_o` = 1 and by 128 otherwise, each output cycle spans 128*N + A oscillator cycles.
- R6: `pulse_o` is high for exactly one count-clock period, the last period of the cycle, which is the period in which the main counter is at zero.
- R7: A valid load (`load_i` = 1 with A < N) updates the shadow registers at that clock edge and takes effect at the next reload. If the load edge is itself a reload edge, the counters reload with the old values and the new values apply one cycle later.
- R8: A load with A >= N is ignored and `cfg_err_o` goes to 1 after that edge. `cfg_err_o` returns to 0 after the next valid load.
- R9: A = 0 gives no divide-by-129 period. N = 1 with A = 0 gives a one-period cycle, with `pulse_o` high on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock (prescaler output) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Strobe to capture a_val_i/n_val_i into the shadow registers |
| a_val_i | input | 7 | Swallow count A |
| n_val_i | input | 10 | Main count N |
| mod_hi_o | output | 1 | 1: prescaler divides by 129, 0: by 128 |
| pulse_o | output | 1 | One-period pulse per output cycle, to the phase detector |
| cfg_err_o | output | 1 | Last load was refused (A >= N) |

## Verification
The hardest case to reach from the ports is a load that lands on the same clock edge as a reload. There the shadow register and the counter reload race, and a wrong ordering would let new values leak into the starting cycle. The stimulus measures each cycle period by period and places the load at a chosen period index. Directed cases put the load exactly on the pulse period, and then verify that one full cycle with the old values is followed by a cycle with the new values. Random (A, N) pairs, loaded at the start of a cycle, then check the period count, the count of divide-by-129 periods and the 128*N + A ratio through a bench prescaler model.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int unsigned PSC_BASE = 128;
  localparam int unsigned A_W      = $clog2(PSC_BASE);
  localparam int unsigned N_W      = 10;

  typedef enum logic {
    MOD_LO = 1'b0,
    MOD_HI = 1'b1
  } mod_e;
endpackage

// File: rtl/swc_shadow.sv
module swc_shadow #(
  parameter int unsigned A_W    = 7,
  parameter int unsigned N_W    = 10,
  parameter int unsigned A_INIT = 5,
  parameter int unsigned N_INIT = 20
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [A_W-1:0] a_i,
  input  logic [N_W-1:0] n_i,
  output logic [A_W-1:0] a_sh_o,
  output logic [N_W-1:0] n_sh_o,
  output logic           err_o
);
  localparam int unsigned EXT = N_W - A_W;

  logic pair_ok;
  assign pair_ok = ({{EXT{1'b0}}, a_i} < n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_sh_o <= A_W'(A_INIT);
      n_sh_o <= N_W'(N_INIT);
      err_o  <= 1'b0;
    end else if (load_i) begin
      if (pair_ok) begin
        a_sh_o <= a_i;
        n_sh_o <= n_i;
        err_o  <= 1'b0;
      end else begin
        err_o  <= 1'b1;
      end
    end
  end

  p_shadow_a_lt_n_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {{EXT{1'b0}}, a_sh_o} < n_sh_o);

  p_bad_load_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !pair_ok) |=> (a_sh_o == $past(a_sh_o)) && (n_sh_o == $past(n_sh_o)) && err_o);
endmodule

// File: rtl/swc_a_cnt.sv
module swc_a_cnt #(
  parameter int unsigned A_W    = 7,
  parameter int unsigned A_INIT = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reload_i,
  input  logic [A_W-1:0] val_i,
  output logic           busy_o
);
  logic [A_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= A_W'(A_INIT);
    else if (reload_i)      cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - A_W'(1);
  end

  assign busy_o = (cnt_q != '0);

  p_a_holds_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !reload_i) |=> !busy_o);

  p_a_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> cnt_q == $past(val_i));
endmodule

// File: rtl/swc_n_cnt.sv
module swc_n_cnt #(
  parameter int unsigned N_W    = 10,
  parameter int unsigned N_INIT = 20
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] val_i,
  output logic           term_o
);
  logic [N_W-1:0] cnt_q;

  // counts N-1 .. 0, so a cycle is N periods
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= N_W'(N_INIT - 1);
    else if (term_o)   cnt_q <= val_i - N_W'(1);
    else               cnt_q <= cnt_q - N_W'(1);
  end

  assign term_o = (cnt_q == '0);

  p_n_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |=> cnt_q == $past(val_i) - N_W'(1));
endmodule

// File: rtl/swallow_ctr.sv
module swallow_ctr
  import swc_pkg::*;
#(
  parameter int unsigned A_INIT = 5,
  parameter int unsigned N_INIT = 20
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [A_W-1:0] a_val_i,
  input  logic [N_W-1:0] n_val_i,
  output logic           mod_hi_o,
  output logic           pulse_o,
  output logic           cfg_err_o
);
  logic [A_W-1:0] a_sh;
  logic [N_W-1:0] n_sh;
  logic           a_busy;
  logic           n_term;
  mod_e           mod_sel;

  swc_shadow #(
    .A_W(A_W), .N_W(N_W), .A_INIT(A_INIT), .N_INIT(N_INIT)
  ) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .a_i    (a_val_i),
    .n_i    (n_val_i),
    .a_sh_o (a_sh),
    .n_sh_o (n_sh),
    .err_o  (cfg_err_o)
  );

  swc_a_cnt #(.A_W(A_W), .A_INIT(A_INIT)) u_a_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (n_term),
    .val_i    (a_sh),
    .busy_o   (a_busy)
  );

  swc_n_cnt #(.N_W(N_W), .N_INIT(N_INIT)) u_n_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .val_i  (n_sh),
    .term_o (n_term)
  );

  assign mod_sel  = a_busy ? MOD_HI : MOD_LO;
  assign mod_hi_o = (mod_sel == MOD_HI);
  assign pulse_o  = n_term;

  p_lo_on_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> !mod_hi_o);

  p_no_hi_after_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mod_hi_o && !pulse_o) |=> !mod_hi_o);
endmodule

// File: tb/tb_swallow_ctr.sv
module tb_swallow_ctr;
  localparam int A_W = 7;
  localparam int N_W = 10;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           load_i = 1'b0;
  logic [A_W-1:0] a_val_i = '0;
  logic [N_W-1:0] n_val_i = '0;
  logic           mod_hi_o, pulse_o, cfg_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  swallow_ctr dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input bit ld, input int a, input int n);
    load_i  = ld;
    a_val_i = A_W'(a);
    n_val_i = N_W'(n);
    @(posedge clk_i);
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  // measures one output cycle starting at the current period; optional load at period ld_at
  task automatic run_cycle(input int ld_at, input int la, input int ln,
                           output int per, output int hi, output int vco,
                           output int ord_bad, output int err_after);
    bit seen_lo = 0;
    bit last;
    per = 0; hi = 0; vco = 0; ord_bad = 0; err_after = -1;
    while (1) begin
      if (mod_hi_o) begin hi++; vco += 129; if (seen_lo) ord_bad++; end
      else begin seen_lo = 1; vco += 128; end
      last = pulse_o;
      tick(per == ld_at, la, ln);
      if (per == ld_at) err_after = int'(cfg_err_o);
      per++;
      if (last || per > 5000) break;
    end
  endtask

  task automatic chk_cycle(input string what, input int a, input int n, input int ld_at,
                           input int la, input int ln, output int err_after);
    int per, hi, vco, ob;
    run_cycle(ld_at, la, ln, per, hi, vco, ob, err_after);
    chk(per == n, {"R3 period ", what}, per, n);
    chk(hi == a, {"R4 div129 count ", what}, hi, a);
    chk(vco == 128*n + a, {"R5 ratio ", what}, vco, 128*n + a);
    chk(ob == 0, {"R2 order ", what}, ob, 0);
  endtask

  initial begin
    int e, a, n, pa, pn;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk(mod_hi_o == 1'b1, "R1 mod_hi", int'(mod_hi_o), 1);
    chk(pulse_o == 1'b0, "R1 pulse", int'(pulse_o), 0);
    chk(cfg_err_o == 1'b0, "R1 err", int'(cfg_err_o), 0);
    chk_cycle("init", 5, 20, -1, 0, 0, e);
    // R6 pulse gone on first period of the next cycle
    chk(pulse_o == 1'b0, "R6 pulse width", int'(pulse_o), 0);

    // R7 mid-cycle load: current cycle unchanged
    chk_cycle("R7 mid load", 5, 20, 3, 10, 40, e);
    chk(e == 0, "R7 err after valid load", e, 0);
    chk_cycle("R7 new vals", 10, 40, -1, 0, 0, e);

    // R7 load on reload edge (last period)
    chk_cycle("R7 edge load", 10, 40, 39, 33, 50, e);
    chk_cycle("R7 old after edge", 10, 40, -1, 0, 0, e);
    chk_cycle("R7 new after edge", 33, 50, -1, 0, 0, e);

    // R8 invalid load A==N, then A>N
    chk_cycle("R8 bad load", 33, 50, 5, 12, 12, e);
    chk(e == 1, "R8 err raised", e, 1);
    chk_cycle("R8 kept", 33, 50, 2, 100, 64, e);
    chk(e == 1, "R8 err still", e, 1);
    chk_cycle("R8 kept 2", 33, 50, 0, 0, 7, e);
    chk(e == 0, "R8 err cleared", e, 0);

    // R9 A=0
    chk_cycle("R9 A0", 0, 7, 0, 0, 1, e);
    // R9 N=1: pulse every period
    chk_cycle("R9 N1", 0, 1, -1, 0, 0, e);
    chk(pulse_o == 1'b1, "R9 pulse steady", int'(pulse_o), 1);
    chk(mod_hi_o == 1'b0, "R9 no div129", int'(mod_hi_o), 0);
    chk_cycle("R9 N1 b", 0, 1, 0, 127, 128, e);
    chk_cycle("R9 switch", 0, 1, -1, 0, 0, e);
    chk_cycle("max", 127, 128, -1, 0, 0, e);

    // random pairs, loaded at period 0 and checked on the following cycle
    pa = 127; pn = 128;
    for (int i = 0; i < 24; i++) begin
      n = 2 + int'($urandom % 299);
      a = int'($urandom % ((n - 1 < 127) ? n : 128));
      chk_cycle("R5 rnd prev", pa, pn, 0, a, n, e);
      chk_cycle("R5 rnd", a, n, -1, 0, 0, e);
      pa = a; pn = n;
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule